// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned WIDTH-bit operand by another. It spends one clock cycle per quotient bit and finishes with a single correction cycle. Three registers hold the working values. The divisor is kept in a register one bit wider than the operands. The dividend is shifted out of the quotient register while quotient bits are shifted in. The partial remainder is kept in a signed register one bit wider than the operands.

Each iteration does the following:
- The partial remainder and quotient registers shift left together by one bit.
- The divisor is then subtracted from the partial remainder or added to it. The choice depends on the sign the remainder had before the shift.
- The new sign sets the incoming quotient bit.

After the last iteration, a negative remainder is corrected once by adding the divisor back. No restore step is needed within the loop.

A caller drives both operands, then pulses `start` for one cycle while the block is idle. `busy` is high while the division runs. `ready` rises when the result is valid and stays high until the next accepted start. Division by zero needs no special path: the same sequence ends with an all-ones quotient and the dividend as the remainder.

Top module: `seq_nr_divider`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `ready`, `quotient` and `remainder` are all zero until a start is accepted.
- R2: A `start` sampled high while `busy` is low loads the operands. It drives `busy` high and `ready` low from the next cycle.
- R3: `busy` stays high for exactly WIDTH+1 cycles after an accepted start. `ready` rises in the same cycle that `busy` falls.
- R4: With a non-zero divisor, `quotient` equals the integer part of dividend/divisor whenever `ready` is high.
- R5: With a non-zero divisor, `remainder` equals dividend modulo divisor whenever `ready` is high, and so it is less than the divisor.
- R6: Dividing 8 by 3 yields quotient 2 and remainder 2.
- R7: A zero divisor completes in the normal time, with `quotient` all ones and `remainder` equal to the dividend.
- R8: A `start` pulse while `busy` is high is ignored. The running division finishes with its original operands and in its original time.
- R9: While `ready` is high and `start` is low, `quotient`, `remainder` and `ready` hold their values, even when the operand inputs change.
- R10: `busy` and `ready` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | WIDTH | Unsigned dividend, sampled with an accepted start |
| divisor | input | WIDTH | Unsigned divisor, sampled with an accepted start |
| busy | output | 1 | High while a division is in progress |
| ready | output | 1 | High while the held result is valid |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |

## Verification
The assertions assume three things:
- Operands matter only in the cycle where `start` is accepted.
- `start` is a single-cycle pulse.
- `rst` is applied before the first start.

The stimulus obeys this by driving operands and `start` together on the falling edge and releasing `start` one cycle later. It deliberately breaks only the idle condition, by pulsing `start` during a running division, and it changes the operand inputs freely while the result is held. Every dividend and divisor pair of the default width is exercised, including a zero divisor. A cycle-level reference model predicts `busy`, `ready` and the results.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    localparam int DEF_WIDTH = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_FIX
    } nrdiv_state_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_STEP,
        OP_FIX
    } nrdiv_op_t;

    function automatic int step_cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/nrdiv_addsub.sv
module nrdiv_addsub #(
    parameter int BITS = 5
) (
    input  logic [BITS-1:0] x,
    input  logic [BITS-1:0] y,
    input  logic            sub,
    output logic [BITS-1:0] sum
);
    logic [BITS:0]   carry;
    logic [BITS-1:0] y_eff;

    assign carry[0] = sub;
    assign y_eff    = y ^ {BITS{sub}};

    for (genvar i = 0; i < BITS; i++) begin : g_bit
        assign sum[i]     = x[i] ^ y_eff[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y_eff[i]) | (carry[i] & (x[i] ^ y_eff[i]));
    end
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output nrdiv_op_t op,
    output logic      busy,
    output logic      ready
);
    localparam int CW = step_cnt_bits(WIDTH);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    nrdiv_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ready_q, ready_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ready_d = ready_q;
        op      = OP_HOLD;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    op      = OP_LOAD;
                    state_d = ST_ITER;
                    cnt_d   = '0;
                    ready_d = 1'b0;
                end
            end
            ST_ITER: begin
                op    = OP_STEP;
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == LAST_STEP) begin
                    state_d = ST_FIX;
                end
            end
            ST_FIX: begin
                op      = OP_FIX;
                state_d = ST_IDLE;
                ready_d = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ready_q <= ready_d;
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign ready = ready_q;
endmodule

// File: rtl/nrdiv_datapath.sv
module nrdiv_datapath
    import nrdiv_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  nrdiv_op_t        op,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quot,
    output logic [WIDTH-1:0] rem,
    output logic [WIDTH-1:0] div_held
);
    localparam int AW = WIDTH + 1;

    logic [AW-1:0]    part_q;
    logic [WIDTH-1:0] qreg_q;
    logic [AW-1:0]    dvsr_q;

    logic [AW-1:0]    shifted;
    logic [AW-1:0]    add_x;
    logic             add_sub;
    logic [AW-1:0]    add_out;
    logic [WIDTH:0]   q_next;

    // The sign before the shift picks subtract (non-negative) or add (negative).
    assign shifted = {part_q[WIDTH-1:0], qreg_q[WIDTH-1]};
    assign add_x   = (op == OP_FIX) ? part_q : shifted;
    assign add_sub = (op == OP_STEP) && !part_q[WIDTH];
    assign q_next  = {qreg_q, ~add_out[WIDTH]};

    nrdiv_addsub #(.BITS(AW)) u_addsub (
        .x   (add_x),
        .y   (dvsr_q),
        .sub (add_sub),
        .sum (add_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            qreg_q <= '0;
            dvsr_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    part_q <= '0;
                    qreg_q <= dividend;
                    dvsr_q <= {1'b0, divisor};
                end
                OP_STEP: begin
                    part_q <= add_out;
                    qreg_q <= q_next[WIDTH-1:0];
                end
                OP_FIX: begin
                    if (part_q[WIDTH]) begin
                        part_q <= add_out;
                    end
                end
                default: ;
            endcase
        end
    end

    assign quot     = qreg_q;
    assign rem      = part_q[WIDTH-1:0];
    assign div_held = dvsr_q[WIDTH-1:0];
endmodule

// File: rtl/seq_nr_divider.sv
module seq_nr_divider
    import nrdiv_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             ready,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    nrdiv_op_t        op;
    logic [WIDTH-1:0] m_val;

    nrdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (op),
        .busy  (busy),
        .ready (ready)
    );

    nrdiv_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .dividend (dividend),
        .divisor  (divisor),
        .quot     (quotient),
        .rem      (remainder),
        .div_held (m_val)
    );
endmodule

// File: rtl/seq_nr_divider_chk.sv
module seq_nr_divider_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             ready,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input logic [WIDTH-1:0] div_held
);
    logic [31:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (start && !busy) begin
            lat_q <= 32'd1;
        end else if (busy) begin
            lat_q <= lat_q + 32'd1;
        end
    end

    AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && ready)); // R10

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !ready)); // R2

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (ready && lat_q == 32'(WIDTH + 2))); // R3

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> (ready && $stable(quotient) && $stable(remainder))); // R9

    AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
        (ready && div_held != '0) |-> (remainder < div_held)); // R5
endmodule

bind seq_nr_divider seq_nr_divider_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .ready     (ready),
    .quotient  (quotient),
    .remainder (remainder),
    .div_held  (m_val)
);

// File: tb/seq_nr_divider_test.sv
`timescale 1ns/1ps
module seq_nr_divider_test;
    localparam int W = 4;
    localparam int LAT = W + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, ready;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit exp_busy = 0, exp_ready = 0;
    int exp_cnt = 0, exp_q = 0, exp_r = 0, op_a = 0, op_b = 0;

    always #2.5 clk = ~clk;

    seq_nr_divider #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .ready(ready),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Behavioural cycle model
    always @(posedge clk) begin
        if (rst) begin
            exp_busy = 0; exp_ready = 0; exp_cnt = 0;
        end else if (exp_busy) begin
            exp_cnt--;
            if (exp_cnt == 0) begin
                exp_busy = 0;
                exp_ready = 1;
                if (op_b == 0) begin
                    exp_q = (1 << W) - 1;
                    exp_r = op_a;
                end else begin
                    exp_q = op_a / op_b;
                    exp_r = op_a % op_b;
                end
            end
        end else if (start) begin
            exp_busy = 1; exp_ready = 0; exp_cnt = LAT;
            op_a = int'(dividend); op_b = int'(divisor);
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2/busy", int'(busy), int'(exp_busy));
            chk("R3/ready", int'(ready), int'(exp_ready));
            chk("R10 exclusive", int'(busy && ready), 0);
            if (exp_ready) begin
                chk("R4 quotient", int'(quotient), exp_q);
                chk("R5 remainder", int'(remainder), exp_r);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    task automatic divide(input int a, input int b);
        @(negedge clk);
        dividend = W'(a);
        divisor  = W'(b);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ready", int'(ready), 0);
        chk("R1 quotient", int'(quotient), 0);
        chk("R1 remainder", int'(remainder), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 idle busy", int'(busy), 0);
        chk("R1 idle quotient", int'(quotient), 0);

        // R6: worked example
        divide(8, 3);
        chk("R6 quotient", int'(quotient), 2);
        chk("R6 remainder", int'(remainder), 2);
        chk("R3 ready at latency", int'(ready), 1);

        // R7: zero divisor
        divide(11, 0);
        chk("R7 quotient", int'(quotient), (1 << W) - 1);
        chk("R7 remainder", int'(remainder), 11);

        // R9: hold while operands change
        for (int k = 0; k < 4; k++) begin
            dividend = W'(k + 5);
            divisor  = W'(k);
            @(negedge clk);
            chk("R9 hold quotient", int'(quotient), (1 << W) - 1);
            chk("R9 hold remainder", int'(remainder), 11);
            chk("R9 hold ready", int'(ready), 1);
        end

        // R8: start during busy is ignored
        @(negedge clk);
        dividend = 4'd13; divisor = 4'd4; start = 1'b1;
        @(negedge clk);
        dividend = 4'd2;  divisor = 4'd7;
        @(negedge clk);
        start = 1'b0;
        chk("R8 still busy", int'(busy), 1);
        repeat (LAT - 1) @(negedge clk);
        chk("R8 quotient", int'(quotient), 3);
        chk("R8 remainder", int'(remainder), 1);
        chk("R8 ready on time", int'(ready), 1);

        // R4/R5: every operand pair
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                divide(a, b);
            end
        end

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule